// File: doc/BRIEF.md
# Peripheral Register Bank with Interrupt Masking

This block is the register front end of one peripheral on a 32-bit, word-only peripheral bus. Software reaches it through a plain bus with address, write data, write and read strobes, and read data. It holds four things:

- a write-only command register that turns each written one into a single-cycle command pulse;
- a read/write mode register;
- a channel-enable state built from write-one set and clear registers, with a read-only view of the result;
- an interrupt mask that is set and cleared in the same way.

The peripheral core supplies a status vector. The block masks it and ORs the result into one interrupt request for the system interrupt controller.

Set/clear pairs with write-one semantics let software change single bits without a read-modify-write sequence. The core can also clear enable bits directly through a hardware clear vector. When both sources act on the same bit in the same cycle, the clear wins.

Register map, as byte offsets. Address bits [1:0] are ignored, and bits [ADDR_W-1:2] select the word:

| Offset | Register |
|---|---|
| 0x00 | command |
| 0x04 | mode |
| 0x08 | enable-set |
| 0x0C | enable-clear |
| 0x10 | enable state |
| 0x14 | mask-set |
| 0x18 | mask-clear |
| 0x1C | mask readback |
| 0x20 | core status |

Top module: `prs_regbank`

## Requirements
- R1: A write to offset 0x00 drives cmd_pulse_o with wdata[CMD_W-1:0] for exactly the one cycle after the write edge. Zero bits give no pulse, and a read of 0x00 returns 0.
- R2: The mode register at 0x04 stores wdata[MODE_W-1:0] on a write, drives mode_o, and reads back with bits above MODE_W as 0.
- R3: A write to 0x08 sets every en_state_o bit whose wdata bit is one. Bits written as zero keep their value.
- R4: A write to 0x0C clears every en_state_o bit whose wdata bit is one. Bits written as zero keep their value. A read of 0x10 returns en_state_o, zero-extended.
- R5: A bit of hw_clr_i clears the matching en_state_o bit on the next edge. This holds even when the same edge sets that bit through a write to 0x08.
- R6: Writes of ones to 0x14 set interrupt-mask bits, and writes of ones to 0x18 clear them. Zero bits have no effect, and 0x1C reads the mask zero-extended.
- R7: irq_o equals the OR over all bits of (status_i AND mask). It is registered: it follows a status change at the next edge, and a mask write one edge after the write edge.
- R8: Address bits [1:0] are ignored, so a byte or half-word address inside a register acts on the whole word.
- R9: Reads of offsets 0x24 and above return 0. Writes to them change no register.
- R10: rd_data_o carries the selected register one cycle after a read strobe and is 0 in cycles with no read. Offset 0x20 returns status_i.
- R11: While rst is high, all outputs and registers go to 0, including mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| status_i | input | INT_W | Status vector from the peripheral core |
| hw_clr_i | input | EN_W | Core-side clear of enable state bits |
| cmd_pulse_o | output | CMD_W | One-cycle command pulses |
| mode_o | output | MODE_W | Mode register contents |
| en_state_o | output | EN_W | Enable state vector |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Every register write takes effect at its write edge. The bench therefore samples mode, enable state and pulse outputs at the falling edge just after that write edge, and checks the pulse again one cycle later to confirm it is gone.

Read data is due one edge after the read strobe and is sampled at the following falling edge. The interrupt output is due one edge after a status change and two edges after a mask write. The bench checks both moments around the mask write, so it confirms the output has not yet moved at the first sample and has moved at the second.

The status sweep covers all 256 status patterns against several masks, with each expected value computed as the OR of the AND.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int IDX_CMD  = 0;
  localparam int IDX_MODE = 1;
  localparam int IDX_ENS  = 2;
  localparam int IDX_ENC  = 3;
  localparam int IDX_ENR  = 4;
  localparam int IDX_IMS  = 5;
  localparam int IDX_IMC  = 6;
  localparam int IDX_IMR  = 7;
  localparam int IDX_STS  = 8;

  typedef struct packed {
    logic cmd;
    logic mode;
    logic ens;
    logic enc;
    logic enr;
    logic ims;
    logic imc;
    logic imr;
    logic sts;
  } sel_t;
endpackage

// File: rtl/prs_addr_dec.sv
module prs_addr_dec #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output prs_pkg::sel_t     sel
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;

  // word index only: low byte-lane bits never take part
  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    sel = '0;
    case (int'(idx))
      prs_pkg::IDX_CMD:  sel.cmd  = 1'b1;
      prs_pkg::IDX_MODE: sel.mode = 1'b1;
      prs_pkg::IDX_ENS:  sel.ens  = 1'b1;
      prs_pkg::IDX_ENC:  sel.enc  = 1'b1;
      prs_pkg::IDX_ENR:  sel.enr  = 1'b1;
      prs_pkg::IDX_IMS:  sel.ims  = 1'b1;
      prs_pkg::IDX_IMC:  sel.imc  = 1'b1;
      prs_pkg::IDX_IMR:  sel.imr  = 1'b1;
      prs_pkg::IDX_STS:  sel.sts  = 1'b1;
      default:           sel      = '0;
    endcase
  end
endmodule

// File: rtl/prs_setclr_reg.sv
module prs_setclr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // clear has priority over set on the same bit
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/prs_irq_gen.sv
module prs_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_i & mask_i);
  end
endmodule

// File: rtl/prs_regbank.sv
module prs_regbank #(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 4,
  parameter int MODE_W = 12,
  parameter int EN_W   = 4,
  parameter int INT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data_o,
  input  logic [INT_W-1:0]  status_i,
  input  logic [EN_W-1:0]   hw_clr_i,
  output logic [CMD_W-1:0]  cmd_pulse_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [EN_W-1:0]   en_state_o,
  output logic              irq_o
);
  prs_pkg::sel_t    sel;
  logic [EN_W-1:0]  en_set, en_clr;
  logic [INT_W-1:0] im_set, im_clr, mask_q;
  logic [31:0]      rmux;

  prs_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

  assign en_set = (wr_en && sel.ens) ? wdata[EN_W-1:0] : '0;
  assign en_clr = ((wr_en && sel.enc) ? wdata[EN_W-1:0] : '0) | hw_clr_i;
  assign im_set = (wr_en && sel.ims) ? wdata[INT_W-1:0] : '0;
  assign im_clr = (wr_en && sel.imc) ? wdata[INT_W-1:0] : '0;

  prs_setclr_reg #(.W(EN_W)) u_en (
    .clk(clk), .rst(rst), .set_i(en_set), .clr_i(en_clr), .q_o(en_state_o));

  prs_setclr_reg #(.W(INT_W)) u_mask (
    .clk(clk), .rst(rst), .set_i(im_set), .clr_i(im_clr), .q_o(mask_q));

  prs_irq_gen #(.W(INT_W)) u_irq (
    .clk(clk), .rst(rst), .status_i(status_i), .mask_i(mask_q), .irq_o(irq_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pulse_o <= '0;
      mode_o      <= '0;
    end else begin
      cmd_pulse_o <= (wr_en && sel.cmd) ? wdata[CMD_W-1:0] : '0;
      if (wr_en && sel.mode) mode_o <= wdata[MODE_W-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    if (sel.mode) rmux = 32'(mode_o);
    if (sel.enr)  rmux = 32'(en_state_o);
    if (sel.imr)  rmux = 32'(mask_q);
    if (sel.sts)  rmux = 32'(status_i);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data_o <= '0;
    else if (rd_en) rd_data_o <= rmux;
    else            rd_data_o <= '0;
  end
endmodule

// File: rtl/prs_regbank_chk.sv
module prs_regbank_chk #(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 4,
  parameter int MODE_W = 12,
  parameter int EN_W   = 4,
  parameter int INT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rd_data_o,
  input logic [INT_W-1:0]  status_i,
  input logic [EN_W-1:0]   hw_clr_i,
  input logic [CMD_W-1:0]  cmd_pulse_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [EN_W-1:0]   en_state_o,
  input logic              irq_o
);
  localparam int LAST_IDX = prs_pkg::IDX_STS;

  // R1
  cmd_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|cmd_pulse_o) |-> $past(wr_en && (int'(addr[ADDR_W-1:2]) == prs_pkg::IDX_CMD)));

  // R5
  hw_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|hw_clr_i) |=> ((en_state_o & $past(hw_clr_i)) == '0));

  // R6
  mask_clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(addr[ADDR_W-1:2]) == prs_pkg::IDX_IMC) && (&wdata[INT_W-1:0]))
    |=> ##1 !irq_o);

  // R7
  no_status_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !(|status_i) |=> !irq_o);

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (int'(addr[ADDR_W-1:2]) > LAST_IDX)) |=> (rd_data_o == '0));

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data_o == '0));

  // R11
  mode_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_o == '0));
endmodule

bind prs_regbank prs_regbank_chk #(
  .ADDR_W(ADDR_W), .CMD_W(CMD_W), .MODE_W(MODE_W), .EN_W(EN_W), .INT_W(INT_W)
) u_chk (.*);

// File: tb/prs_regbank_bench.sv
`timescale 1ns/1ps
module prs_regbank_bench;
  localparam int ADDR_W = 8;
  localparam int CMD_W  = 4;
  localparam int MODE_W = 12;
  localparam int EN_W   = 4;
  localparam int INT_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rd_data_o;
  logic [INT_W-1:0]  status_i = '0;
  logic [EN_W-1:0]   hw_clr_i = '0;
  logic [CMD_W-1:0]  cmd_pulse_o;
  logic [MODE_W-1:0] mode_o;
  logic [EN_W-1:0]   en_state_o;
  logic              irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  prs_regbank #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .MODE_W(MODE_W),
                .EN_W(EN_W), .INT_W(INT_W)) u_prs_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data_o(rd_data_o), .status_i(status_i),
    .hw_clr_i(hw_clr_i), .cmd_pulse_o(cmd_pulse_o), .mode_o(mode_o),
    .en_state_o(en_state_o), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic set_mask(input logic [INT_W-1:0] m);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h14, 32'(m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [EN_W-1:0] e_model;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 cmd", 32'(cmd_pulse_o), 0);
    chk("R11 mode", 32'(mode_o), 0);
    chk("R11 en", 32'(en_state_o), 0);
    chk("R11 irq", 32'(irq_o), 0);
    chk("R11 rdata", rd_data_o, 0);
    rd(8'h1C, 0, "R11 mask readback");

    // R2 mode register, unused bits read 0
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R2 mode port", 32'(mode_o), 32'h0000_0FFF);
    rd(8'h04, 32'h0000_0FFF, "R2 mode read");
    // R10 no read -> 0
    @(negedge clk);
    chk("R10 idle rdata", rd_data_o, 0);

    // R8 sub-word addresses
    wr(8'h05, 32'h0000_0123);
    chk("R8 mode via 0x05", 32'(mode_o), 32'h123);
    rd(8'h07, 32'h123, "R8 read via 0x07");
    rd(8'h12, 0, "R8 enable state via 0x12");

    // R1 command pulses
    wr(8'h00, 32'h0000_0005);
    chk("R1 pulse", 32'(cmd_pulse_o), 5);
    @(negedge clk);
    chk("R1 pulse ends", 32'(cmd_pulse_o), 0);
    wr(8'h03, 32'h0000_000A);
    chk("R1 pulse sub-word", 32'(cmd_pulse_o), 32'hA);
    wr(8'h00, 32'h0000_0000);
    chk("R1 zero write", 32'(cmd_pulse_o), 0);
    rd(8'h00, 0, "R1 command read");

    // R3 / R4 sweep
    e_model = '0;
    for (int v = 0; v < 16; v++) begin
      wr(8'h08, 32'(v));
      e_model = e_model | EN_W'(v);
      chk("R3 set", 32'(en_state_o), 32'(e_model));
      wr(8'h0C, 32'(v ^ 3));
      e_model = e_model & ~EN_W'(v ^ 3);
      chk("R4 clear", 32'(en_state_o), 32'(e_model));
      rd(8'h10, 32'(e_model), "R4 readback");
    end

    // R5 hw clear beats bus set
    wr(8'h0C, 32'hF);
    hw_clr_i = 4'b0101;
    wr(8'h08, 32'hF);
    hw_clr_i = '0;
    chk("R5 clear wins", 32'(en_state_o), 32'b1010);
    hw_clr_i = 4'b1000;
    @(negedge clk);
    hw_clr_i = '0;
    chk("R5 hw clear alone", 32'(en_state_o), 32'b0010);

    // R6 mask set/clear
    set_mask(8'hA5);
    rd(8'h1C, 32'hA5, "R6 mask set");
    wr(8'h18, 32'h05);
    rd(8'h1C, 32'hA0, "R6 mask clear");
    wr(8'h14, 32'h00);
    wr(8'h18, 32'h00);
    rd(8'h1C, 32'hA0, "R6 zero writes");

    // R9 unmapped
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    chk("R9 cmd untouched", 32'(cmd_pulse_o), 0);
    rd(8'h24, 0, "R9 read 0x24");
    rd(8'hFC, 0, "R9 read 0xFC");
    rd(8'h04, 32'h123, "R9 mode kept");
    rd(8'h10, 32'b0010, "R9 enable kept");
    rd(8'h1C, 32'hA0, "R9 mask kept");

    // R10 status readback
    status_i = 8'h5A;
    rd(8'h20, 32'h5A, "R10 status read");

    // R7 latency from mask write
    set_mask(8'h00);
    status_i = 8'h01;
    @(negedge clk);
    chk("R7 masked", 32'(irq_o), 0);
    wr(8'h14, 32'h01);
    chk("R7 not yet", 32'(irq_o), 0);
    @(negedge clk);
    chk("R7 after mask", 32'(irq_o), 1);

    // R7 exhaustive status sweep
    for (int mi = 0; mi < 4; mi++) begin
      logic [INT_W-1:0] m;
      m = (mi == 0) ? 8'hFF : (mi == 1) ? 8'h3C : (mi == 2) ? 8'h81 : 8'h00;
      set_mask(m);
      for (int s = 0; s < 256; s++) begin
        status_i = INT_W'(s);
        @(negedge clk);
        chk("R7 sweep", 32'(irq_o), 32'(|(INT_W'(s) & m)));
      end
    end
    status_i = '0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule